// File: doc/BRIEF.md
# Raster Cursor Generator with Blink

This block drives the active-high cursor signal of a character-based raster display controller. On every character clock it compares the refresh memory address of the character being fetched against a programmed cursor location. It also checks that the current row address lies inside a programmed band of scan lines. When both match, display enable is high, and the mode allows it, the cursor output asserts.

A two-bit mode field, carried in the upper bits of the cursor start value, selects one of four behaviours: steady, off, or one of two blink rates. For blinking, a small field counter advances once per frame-start pulse. One of its bits sets the visible and hidden halves of the blink period, at 1/16 or 1/32 of the field rate. The output is registered by default, so it lines up with video that leaves the fetch pipeline one clock later.

Top module: `crt_cursor_gen`

## Requirements
- R1: The cursor output can assert only in a cycle after a clock edge at which `refresh_addr` equalled `cur_addr` (all 14 bits).
- R2: The cursor output can assert only when the sampled `row_addr` satisfies start <= row <= end. Start is `cur_start_reg[4:0]` and end is `cur_end_line`. When start is greater than end, the cursor never asserts.
- R3: The mode field is `cur_start_reg[6:5]`. The value 2'b01 turns the cursor off, so the output stays low whatever the other inputs are.
- R4: Mode 2'b00 is steady. The output asserts whenever address, line window and display enable all match, whatever the field counter holds.
- R5: Mode 2'b10 blinks fast. The cursor is shown while bit 3 of the field counter is 0 and hidden while it is 1, giving a period of 16 frames.
- R6: Mode 2'b11 blinks slowly. The cursor is shown while bit 4 of the field counter is 0 and hidden while it is 1, giving a period of 32 frames.
- R7: The 5-bit field counter resets to 0. It advances by one at each clock edge where `frame_start` is high, and wraps from 31 to 0.
- R8: The cursor output is low whenever display enable was low at the sampling edge, so it never asserts during retrace.
- R9: With the default configuration, the output is registered. The value at a clock edge reflects the inputs and the field counter just before that edge, and it reads 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-clock pulse at the start of each field |
| disp_en | input | 1 | Display enable from the raster timing |
| refresh_addr | input | 14 | Refresh memory address of the current character |
| row_addr | input | 5 | Scan line within the current character row |
| cur_start_reg | input | 7 | [6:5] cursor mode, [4:0] first cursor scan line |
| cur_end_line | input | 5 | Last cursor scan line |
| cur_addr | input | 14 | Linear address of the cursor character |
| cursor_out | output | 1 | Cursor video, active high |

## Verification
The bench builds the block with its default parameters: a 14-bit address, 5-bit lines, a 5-bit field counter using bits 3 and 4 for the blink phase, and a registered output. With only a 32-frame counter wrap, random frame pulses cycle both blink rates many times, including the wrap from 31 to 0. Random address and line values are biased toward the cursor location, so exact-match hits and the inclusive edges of the line band come up often. Directed cases cover inverted bands, equal start and end, the off mode, and the one-clock output latency.

// File: rtl/crt_cursor_pkg.sv
package crt_cursor_pkg;
   typedef enum logic [1:0] {
      CUR_STEADY = 2'b00,
      CUR_OFF    = 2'b01,
      CUR_BLINKF = 2'b10,
      CUR_BLINKS = 2'b11
   } cur_mode_e;
endpackage

// File: rtl/crt_cursor_addr_match.sv
module crt_cursor_addr_match #(
   parameter int ADDR_W = 14
) (
   input  logic [ADDR_W-1:0] scan_addr,
   input  logic [ADDR_W-1:0] target_addr,
   output logic              addr_hit
);
   always_comb addr_hit = (scan_addr == target_addr);
endmodule

// File: rtl/crt_cursor_line_window.sv
module crt_cursor_line_window #(
   parameter int LINE_W = 5
) (
   input  logic [LINE_W-1:0] line_now,
   input  logic [LINE_W-1:0] line_first,
   input  logic [LINE_W-1:0] line_last,
   output logic              line_hit
);
   logic above_first;
   logic below_last;
   always_comb begin
      above_first = (line_now >= line_first);
      below_last  = (line_now <= line_last);
      line_hit    = above_first & below_last;
   end
endmodule

// File: rtl/crt_cursor_blink.sv
module crt_cursor_blink
   import crt_cursor_pkg::*;
#(
   parameter int FCNT_W   = 5,
   parameter int FAST_BIT = 3,
   parameter int SLOW_BIT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  cur_mode_e  mode,
   output logic       show
);
   localparam logic [FCNT_W-1:0] CNT_ONE = {{(FCNT_W-1){1'b0}}, 1'b1};

   logic [FCNT_W-1:0] field_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           field_cnt <= '0;
      else if (frame_start) field_cnt <= field_cnt + CNT_ONE;
   end

   always_comb begin
      unique case (mode)
         CUR_STEADY: show = 1'b1;
         CUR_OFF:    show = 1'b0;
         CUR_BLINKF: show = ~field_cnt[FAST_BIT];
         CUR_BLINKS: show = ~field_cnt[SLOW_BIT];
         default:    show = 1'b0;
      endcase
   end
endmodule

// File: rtl/crt_cursor_gen.sv
module crt_cursor_gen
   import crt_cursor_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int LINE_W   = 5,
   parameter int FCNT_W   = 5,
   parameter int FAST_BIT = 3,
   parameter int SLOW_BIT = 4,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              disp_en,
   input  logic [ADDR_W-1:0] refresh_addr,
   input  logic [LINE_W-1:0] row_addr,
   input  logic [LINE_W+1:0] cur_start_reg,
   input  logic [LINE_W-1:0] cur_end_line,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              cursor_out
);
   localparam int MODE_LSB = LINE_W;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("crt_cursor_gen: ADDR_W must be positive");
   end
   if (LINE_W < 1) begin : g_bad_line
      $error("crt_cursor_gen: LINE_W must be positive");
   end
   if (!(FAST_BIT < SLOW_BIT && SLOW_BIT < FCNT_W)) begin : g_bad_bits
      $error("crt_cursor_gen: need FAST_BIT < SLOW_BIT < FCNT_W");
   end

   cur_mode_e mode;
   logic      addr_hit;
   logic      line_hit;
   logic      show;
   logic      cursor_c;

   always_comb mode = cur_mode_e'(cur_start_reg[MODE_LSB +: 2]);

   crt_cursor_addr_match #(.ADDR_W(ADDR_W)) u_addr (
      .scan_addr   (refresh_addr),
      .target_addr (cur_addr),
      .addr_hit    (addr_hit)
   );

   crt_cursor_line_window #(.LINE_W(LINE_W)) u_line (
      .line_now   (row_addr),
      .line_first (cur_start_reg[LINE_W-1:0]),
      .line_last  (cur_end_line),
      .line_hit   (line_hit)
   );

   crt_cursor_blink #(
      .FCNT_W   (FCNT_W),
      .FAST_BIT (FAST_BIT),
      .SLOW_BIT (SLOW_BIT)
   ) u_blink (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .mode        (mode),
      .show        (show)
   );

   always_comb cursor_c = addr_hit & line_hit & show & disp_en;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cursor_out <= 1'b0;
         else        cursor_out <= cursor_c;
      end
   end else begin : g_out_comb
      always_comb cursor_out = cursor_c;
   end
endmodule

// File: rtl/crt_cursor_chk.sv
module crt_cursor_chk #(
   parameter int ADDR_W  = 14,
   parameter int LINE_W  = 5,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              disp_en,
   input logic [ADDR_W-1:0] refresh_addr,
   input logic [LINE_W-1:0] row_addr,
   input logic [LINE_W+1:0] cur_start_reg,
   input logic [LINE_W-1:0] cur_end_line,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              cursor_out
);
   logic              d_de;
   logic [ADDR_W-1:0] d_addr;
   logic [ADDR_W-1:0] d_caddr;
   logic [LINE_W-1:0] d_row;
   logic [LINE_W+1:0] d_start;
   logic [LINE_W-1:0] d_end;

   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_de <= 1'b0; d_addr <= '0; d_caddr <= '0;
            d_row <= '0; d_start <= '0; d_end <= '0;
         end else begin
            d_de <= disp_en; d_addr <= refresh_addr; d_caddr <= cur_addr;
            d_row <= row_addr; d_start <= cur_start_reg; d_end <= cur_end_line;
         end
      end
   end else begin : g_nodly
      always_comb begin
         d_de = disp_en; d_addr = refresh_addr; d_caddr = cur_addr;
         d_row = row_addr; d_start = cur_start_reg; d_end = cur_end_line;
      end
   end

   AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_out |-> (d_addr == d_caddr)); // R1
   AST_LINE_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_out |-> (d_row >= d_start[LINE_W-1:0] && d_row <= d_end)); // R2
   AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (d_start[LINE_W +: 2] == 2'b01) |-> !cursor_out); // R3
   AST_STEADY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (d_start[LINE_W +: 2] == 2'b00 && d_de && d_addr == d_caddr &&
       d_row >= d_start[LINE_W-1:0] && d_row <= d_end) |-> cursor_out); // R4
   AST_NO_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
      cursor_out |-> d_de); // R8
endmodule

bind crt_cursor_gen crt_cursor_chk #(
   .ADDR_W  (ADDR_W),
   .LINE_W  (LINE_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .disp_en       (disp_en),
   .refresh_addr  (refresh_addr),
   .row_addr      (row_addr),
   .cur_start_reg (cur_start_reg),
   .cur_end_line  (cur_end_line),
   .cur_addr      (cur_addr),
   .cursor_out    (cursor_out)
);

// File: tb/crt_cursor_gen_bench.sv
`timescale 1ns/1ps
module crt_cursor_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        disp_en = 1'b0;
   logic [13:0] refresh_addr = '0;
   logic [4:0]  row_addr = '0;
   logic [6:0]  cur_start_reg = '0;
   logic [4:0]  cur_end_line = '0;
   logic [13:0] cur_addr = '0;
   logic        cursor_out;

   int n_cmp = 0;
   int n_bad = 0;
   int fcnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   crt_cursor_gen u_crt_cursor_gen (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .disp_en(disp_en),
      .refresh_addr(refresh_addr), .row_addr(row_addr),
      .cur_start_reg(cur_start_reg), .cur_end_line(cur_end_line),
      .cur_addr(cur_addr), .cursor_out(cursor_out)
   );

   function automatic bit model(int cnt);
      bit vis;
      case (cur_start_reg[6:5])
         2'b00: vis = 1'b1;
         2'b01: vis = 1'b0;
         2'b10: vis = ((cnt >> 3) & 1) == 0;
         default: vis = ((cnt >> 4) & 1) == 0;
      endcase
      return vis && disp_en && (refresh_addr == cur_addr) &&
             (row_addr >= cur_start_reg[4:0]) && (row_addr <= cur_end_line);
   endfunction

   function automatic string tag_of();
      if (!disp_en) return "R8";
      if (refresh_addr != cur_addr) return "R1";
      if (row_addr < cur_start_reg[4:0] || row_addr > cur_end_line) return "R2";
      case (cur_start_reg[6:5])
         2'b00: return "R4";
         2'b01: return "R3";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input bit act, input bit exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: cursor_out=%0b expected %0b (fcnt=%0d)", tag, act, exp, fcnt);
      end
   endtask

   // drive at negedge, sample 1 ns after the following posedge
   task automatic step(input bit fs, input bit de, input logic [13:0] ra,
                       input logic [4:0] row, input logic [6:0] st,
                       input logic [4:0] en, input logic [13:0] ca,
                       input string force_tag);
      bit exp;
      string tg;
      @(negedge clk);
      frame_start = fs; disp_en = de; refresh_addr = ra; row_addr = row;
      cur_start_reg = st; cur_end_line = en; cur_addr = ca;
      exp = model(fcnt);
      tg = (force_tag == "") ? tag_of() : force_tag;
      @(posedge clk);
      if (fs) fcnt = (fcnt + 1) % 32;
      #1;
      check(cursor_out, exp, tg);
   endtask

   task automatic frames(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); frame_start = 1'b1;
         @(posedge clk); fcnt = (fcnt + 1) % 32;
         @(negedge clk); frame_start = 1'b0;
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_C0DE));
      // R9: reset value with matching inputs while reset held
      disp_en = 1'b1; refresh_addr = 14'h0123; cur_addr = 14'h0123;
      row_addr = 5'd4; cur_start_reg = {2'b00, 5'd2}; cur_end_line = 5'd6;
      repeat (3) @(posedge clk);
      #1 check(cursor_out, 1'b0, "R9");
      @(negedge clk); rst_n = 1'b1;

      // R9: one clock latency - before the edge output is still low
      @(negedge clk); disp_en = 1'b0;
      @(posedge clk); #1 check(cursor_out, 1'b0, "R8");
      @(negedge clk); disp_en = 1'b1;
      #1 check(cursor_out, 1'b0, "R9");
      @(posedge clk); #1 check(cursor_out, 1'b1, "R9");

      // R2: inclusive edges, equal start/end, inverted band
      step(0, 1, 14'h0200, 5'd2,  {2'b00, 5'd2},  5'd6,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd6,  {2'b00, 5'd2},  5'd6,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd7,  {2'b00, 5'd2},  5'd6,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd1,  {2'b00, 5'd2},  5'd6,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd9,  {2'b00, 5'd9},  5'd9,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd5,  {2'b00, 5'd8},  5'd3,  14'h0200, "R2");
      step(0, 1, 14'h0200, 5'd31, {2'b00, 5'd0},  5'd31, 14'h0200, "R2");
      // R1: single-bit address difference, top bit
      step(0, 1, 14'h2200, 5'd4,  {2'b00, 5'd2},  5'd6,  14'h0200, "R1");
      step(0, 1, 14'h3FFF, 5'd4,  {2'b00, 5'd2},  5'd6,  14'h3FFF, "R1");
      // R3: off mode with full match
      step(0, 1, 14'h0010, 5'd3,  {2'b01, 5'd0},  5'd31, 14'h0010, "R3");
      // R8: retrace
      step(0, 0, 14'h0010, 5'd3,  {2'b00, 5'd0},  5'd31, 14'h0010, "R8");

      // R7/R5/R6: walk 64 frames, check both blink modes at each count
      for (int f = 0; f < 64; f++) begin
         step(0, 1, 14'h0ABC, 5'd5, {2'b10, 5'd5}, 5'd5, 14'h0ABC, "R5");
         step(0, 1, 14'h0ABC, 5'd5, {2'b11, 5'd5}, 5'd5, 14'h0ABC, "R6");
         step(0, 1, 14'h0ABC, 5'd5, {2'b00, 5'd5}, 5'd5, 14'h0ABC, "R4");
         step(1, 0, 14'h0ABC, 5'd5, {2'b11, 5'd5}, 5'd5, 14'h0ABC, "R7");
      end

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [13:0] ca;
         logic [13:0] ra;
         logic [4:0]  s;
         logic [4:0]  e;
         logic [4:0]  r;
         ca = 14'($urandom);
         ra = ($urandom_range(0, 1) == 0) ? ca : 14'($urandom);
         s  = 5'($urandom_range(0, 15));
         e  = 5'($urandom_range(0, 31));
         r  = ($urandom_range(0, 3) == 0) ? 5'($urandom) :
              (($urandom_range(0, 1) == 0) ? s : e);
         step(($urandom_range(0, 7) == 0), ($urandom_range(0, 5) != 0), ra, r,
              {2'($urandom), s}, e, ca, "");
      end

      // R7: counter restarts at 0 after reset
      @(negedge clk); rst_n = 1'b0; fcnt = 0;
      @(negedge clk); rst_n = 1'b1;
      frames(8);
      step(0, 1, 14'h0001, 5'd0, {2'b10, 5'd0}, 5'd0, 14'h0001, "R7");
      frames(7);
      step(0, 1, 14'h0001, 5'd0, {2'b10, 5'd0}, 5'd0, 14'h0001, "R7");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule